// File: doc/BRIEF.md
# SDRAM Read Latency and Byte-Mask Pipeline

This block is the data-output path of a synchronous DRAM device model. A read strobe opens a column burst of fixed length. The array word for each burst beat is taken in the beat's own cycle and delayed by the programmed read latency of two or three clocks before it reaches the data pins. A per-byte output enable stands for the driven or high-impedance state of each pin group, and it is low on every cycle that carries no read beat.

Two byte masks act on the data, the lower one on bits 7:0 and the upper one on bits 15:8. On the read side a mask floats its byte two clocks after the mask is sampled. On the write side the same mask blocks its byte of write data in the same cycle. A stop command, which stands for either precharge or burst termination, ends the burst. The beats already under way still leave the pins, so one more beat follows at latency two and two more follow at latency three.

Top module: `sdr_rd_path`

## Requirements
- R1: While reset is held and right after it is released, dqOe is 00 and dqOut is all zeros.
- R2: With latSel equal to 2, a beat taken in cycle C appears on dqOut with dqOe high in cycle C+2.
- R3: With latSel equal to 0, 1 or 3, the latency is three: a beat taken in cycle C appears in cycle C+3.
- R4: A rdIssue in cycle C opens a burst of BURST_LEN (default 4) beats in cycles C to C+BURST_LEN-1. arrData is taken in each beat cycle.
- R5: A rdIssue during a burst restarts the burst in that cycle, so a new read may start on every clock.
- R6: A stopCmd in cycle T cancels the beat of cycle T and all later beats of the burst. This leaves one further output beat at latency two and two at latency three. A rdIssue in the same cycle as a stopCmd still opens its new burst.
- R7: A dqm bit sampled high in cycle M forces its byte low on dqOe and zero on dqOut in cycle M+2. Bit 0 controls bits 7:0 and bit 1 controls bits 15:8, each on its own.
- R8: In every cycle, arrWrBe[b] equals wrEn AND NOT dqm[b], and arrWrData equals wrData, with no clock delay.
- R9: dqOe is 00 and dqOut is zero on every cycle that carries no read beat, including the idle cycles between bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| latSel | input | 2 | Read latency select: 2 gives two clocks, any other value gives three; changed only with no read in flight |
| rdIssue | input | 1 | Read command strobe that opens a burst |
| stopCmd | input | 1 | Precharge or burst-stop strobe |
| arrData | input | 16 | Array word for the current beat |
| dqm | input | 2 | Byte masks: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| wrEn | input | 1 | Write data present this cycle |
| wrData | input | 16 | Write data from the pins |
| dqOut | output | 16 | Read data; a byte reads zero when its enable is low |
| dqOe | output | 2 | Per-byte output enable; low means high impedance |
| arrWrData | output | 16 | Write data toward the array |
| arrWrBe | output | 2 | Per-byte write enable toward the array |

## Verification
A read mask can land on the same cycle as a read beat, and a stop can coincide with a new read strobe. Both are provoked in directed steps: masks of 01, 10 and 11 are placed two cycles ahead of chosen beats, and a stop is issued together with a read. The same collisions are also provoked in long random runs at each latency. A reference model in the bench keeps the history of beats and masks. Each cycle's pins are judged against the beat from the latency-delayed cycle, gated by the mask from two cycles earlier.

// File: rtl/sdr_rd_pkg.sv
`timescale 1ns/1ps
package sdr_rd_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic beat;    // a column beat is taken this cycle
    logic latTwo;  // latency two is selected (else three)
  } rdCtlT;

  localparam int MAX_LAT  = 3;
  localparam int MASK_LAT = 2;
endpackage

// File: rtl/sdr_rd_ctl.sv
`timescale 1ns/1ps
module sdr_rd_ctl
  import sdr_rd_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] latSel,
  input  logic       rdIssue,
  input  logic       stopCmd,
  output rdCtlT      strb
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] beatsLeft;
  logic [CNT_W-1:0] beatsLeftNxt;
  logic             burstOn;

  assign burstOn = (beatsLeft != '0);

  always_comb begin
    strb.beat   = rdIssue | (burstOn & ~stopCmd);
    strb.latTwo = (latSel == 2'd2);
    if (rdIssue)
      beatsLeftNxt = RELOAD;
    else if (stopCmd || !burstOn)
      beatsLeftNxt = '0;
    else
      beatsLeftNxt = beatsLeft - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) beatsLeft <= '0;
    else       beatsLeft <= beatsLeftNxt;
  end

  // R6
  stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && !rdIssue) |=> (strb.beat == rdIssue));

  // R4
  beat_continuity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.beat && !rdIssue) |-> $past(strb.beat));
endmodule

// File: rtl/sdr_rd_dp.sv
`timescale 1ns/1ps
module sdr_rd_dp
  import sdr_rd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtlT             strb,
  input  logic [DATA_W-1:0] arrData,
  input  logic [DATA_W/8-1:0] dqm,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W/8-1:0] dqOe,
  output logic [DATA_W-1:0] arrWrData,
  output logic [DATA_W/8-1:0] arrWrBe
);
  localparam int BYTES = DATA_W / 8;

  logic [MAX_LAT-1:0] vPipe;
  logic [DATA_W-1:0]  dPipe [MAX_LAT];
  logic [BYTES-1:0]   mPipe [MASK_LAT];
  logic               selV;
  logic [DATA_W-1:0]  selD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe[0] <= 1'b0;
      dPipe[0] <= '0;
      mPipe[0] <= '0;
    end else begin
      vPipe[0] <= strb.beat;
      dPipe[0] <= strb.beat ? arrData : '0;
      mPipe[0] <= dqm;
    end
  end

  genvar s;
  generate
    for (s = 1; s < MAX_LAT; s++) begin : g_dstage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          vPipe[s] <= 1'b0;
          dPipe[s] <= '0;
        end else begin
          vPipe[s] <= vPipe[s-1];
          dPipe[s] <= dPipe[s-1];
        end
      end
    end
    for (s = 1; s < MASK_LAT; s++) begin : g_mstage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mPipe[s] <= '0;
        else       mPipe[s] <= mPipe[s-1];
      end
    end
  endgenerate

  // Tap the stage that matches the programmed latency
  always_comb begin
    if (strb.latTwo) begin
      selV = vPipe[1];
      selD = dPipe[1];
    end else begin
      selV = vPipe[MAX_LAT-1];
      selD = dPipe[MAX_LAT-1];
    end
  end

  assign arrWrData = wrData;

  // Cycles since reset, used only to keep lookback assertions in range
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end

  genvar b;
  generate
    for (b = 0; b < BYTES; b++) begin : g_byte
      assign dqOe[b]          = selV & ~mPipe[MASK_LAT-1][b];
      assign dqOut[b*8 +: 8]  = dqOe[b] ? selD[b*8 +: 8] : 8'h00;
      assign arrWrBe[b]       = wrEn & ~dqm[b];

      // R7
      rd_mask_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
        (warm >= 2'd2 && dqOe[b]) |-> !$past(dqm[b], 2));
    end
  endgenerate

  // R2
  lat_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && strb.latTwo && (dqOe != '0)) |-> $past(strb.beat, 2));

  // R3
  lat_three_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && !strb.latTwo && (dqOe != '0)) |-> $past(strb.beat, 3));
endmodule

// File: rtl/sdr_rd_path.sv
`timescale 1ns/1ps
module sdr_rd_path
  import sdr_rd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        latSel,
  input  logic              rdIssue,
  input  logic              stopCmd,
  input  logic [DATA_W-1:0] arrData,
  input  logic [DATA_W/8-1:0] dqm,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W/8-1:0] dqOe,
  output logic [DATA_W-1:0] arrWrData,
  output logic [DATA_W/8-1:0] arrWrBe
);
  rdCtlT strb;

  sdr_rd_ctl #(.BURST_LEN(BURST_LEN)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .latSel  (latSel),
    .rdIssue (rdIssue),
    .stopCmd (stopCmd),
    .strb    (strb)
  );

  sdr_rd_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .arrData   (arrData),
    .dqm       (dqm),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .dqOut     (dqOut),
    .dqOe      (dqOe),
    .arrWrData (arrWrData),
    .arrWrBe   (arrWrBe)
  );
endmodule

// File: tb/sdr_rd_path_tb.sv
`timescale 1ns/1ps
module sdr_rd_path_tb;
  localparam int BL = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  latSel = 2'd3;
  logic        rdIssue = 1'b0;
  logic        stopCmd = 1'b0;
  logic [15:0] arrData = '0;
  logic [1:0]  dqm = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;
  logic [15:0] arrWrData;
  logic [1:0]  arrWrBe;

  always #5 clk = ~clk;

  sdr_rd_path #(.DATA_W(16), .BURST_LEN(BL)) u_dut (
    .clk(clk), .rstN(rstN), .latSel(latSel), .rdIssue(rdIssue),
    .stopCmd(stopCmd), .arrData(arrData), .dqm(dqm), .wrEn(wrEn),
    .wrData(wrData), .dqOut(dqOut), .dqOe(dqOe),
    .arrWrData(arrWrData), .arrWrBe(arrWrBe)
  );

  int    errors = 0;
  int    checks = 0;
  int    cyc = 8;
  int    mLeft = 0;
  bit    done = 1'b0;
  string curTag = "R1";
  bit          hV [8];
  logic [15:0] hD [8];
  logic [1:0]  hM [8];

  function automatic int expLat(input logic [1:0] sel);
    return (sel == 2'd2) ? 2 : 3;
  endfunction

  task automatic checkRead();
    int l = expLat(latSel);
    bit v = hV[(cyc - l) % 8];
    logic [15:0] d = hD[(cyc - l) % 8];
    logic [1:0] m = hM[(cyc - 2) % 8];
    logic [1:0] eo;
    logic [15:0] ed;
    eo[0] = v & ~m[0];
    eo[1] = v & ~m[1];
    ed = {eo[1] ? d[15:8] : 8'h00, eo[0] ? d[7:0] : 8'h00};
    checks++;
    if (dqOe !== eo || dqOut !== ed) begin
      errors++;
      $display("FAIL %s cyc %0d: dqOe=%b dqOut=%h expected dqOe=%b dqOut=%h",
               curTag, cyc, dqOe, dqOut, eo, ed);
    end
  endtask

  task automatic step(input bit rd, input bit st, input logic [1:0] m,
                      input bit we, input logic [15:0] wd);
    bit beat;
    logic [1:0] expBe;
    @(negedge clk);
    checkRead();
    rdIssue = rd; stopCmd = st; dqm = m; wrEn = we; wrData = wd;
    arrData = 16'($urandom);
    beat = rd || (mLeft != 0 && !st);
    if (rd) mLeft = BL - 1;
    else if (st || mLeft == 0) mLeft = 0;
    else mLeft = mLeft - 1;
    hV[cyc % 8] = beat;
    hD[cyc % 8] = arrData;
    hM[cyc % 8] = m;
    #1;
    expBe = {we & ~m[1], we & ~m[0]};
    checks++;
    if (arrWrBe !== expBe || arrWrData !== wd) begin
      errors++;
      $display("FAIL R8 cyc %0d: arrWrBe=%b arrWrData=%h expected arrWrBe=%b arrWrData=%h",
               cyc, arrWrBe, arrWrData, expBe, wd);
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'b00, 1'b0, 16'h0);
  endtask

  task automatic setLat(input logic [1:0] v);
    string keep = curTag;
    curTag = "R9";
    idle(5);
    latSel = v;
    curTag = keep;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin hV[i] = 1'b0; hD[i] = '0; hM[i] = '0; end

    // R1: reset state while held, then just after release
    curTag = "R1";
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dqOe !== 2'b00 || dqOut !== 16'h0) begin
      errors++;
      $display("FAIL R1: dqOe=%b dqOut=%h expected 00 0000", dqOe, dqOut);
    end
    rstN = 1'b1;
    idle(3);

    // R2: latency two, single burst
    curTag = "R2";
    setLat(2'd2);
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    idle(6);

    // R3: every non-two select gives latency three
    curTag = "R3";
    setLat(2'd0); step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0); idle(6);
    setLat(2'd1); step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0); idle(6);
    setLat(2'd3); step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0); idle(6);

    // R4: full burst length, then idle gap checked under R9
    curTag = "R4";
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    idle(3);
    curTag = "R9";
    idle(6);

    // R5: restart mid burst and back to back reads
    curTag = "R5";
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    idle(1);
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    idle(8);

    // R6: stop at latency three, latency two, and stop with a new read
    curTag = "R6";
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    step(1'b0, 1'b0, 2'b00, 1'b0, 16'h0);
    step(1'b0, 1'b1, 2'b00, 1'b0, 16'h0);
    idle(6);
    setLat(2'd2);
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    step(1'b0, 1'b1, 2'b00, 1'b0, 16'h0);
    idle(6);
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    step(1'b1, 1'b1, 2'b00, 1'b0, 16'h0);
    idle(7);

    // R7: per-byte read masks landing on beats two cycles later
    curTag = "R7";
    setLat(2'd3);
    step(1'b1, 1'b0, 2'b00, 1'b0, 16'h0);
    step(1'b0, 1'b0, 2'b01, 1'b0, 16'h0);
    step(1'b0, 1'b0, 2'b10, 1'b0, 16'h0);
    step(1'b0, 1'b0, 2'b11, 1'b0, 16'h0);
    step(1'b0, 1'b0, 2'b00, 1'b0, 16'h0);
    idle(6);

    // R8: write masking in the same cycle
    curTag = "R8";
    step(1'b0, 1'b0, 2'b00, 1'b1, 16'hA55A);
    step(1'b0, 1'b0, 2'b01, 1'b1, 16'h1234);
    step(1'b0, 1'b0, 2'b10, 1'b1, 16'hBEEF);
    step(1'b0, 1'b0, 2'b11, 1'b1, 16'hFFFF);
    step(1'b0, 1'b0, 2'b11, 1'b0, 16'h0F0F);

    // Random mix at both latencies: stops, restarts, masks and writes
    for (int p = 0; p < 2; p++) begin
      curTag = (p == 0) ? "R6" : "R7";
      setLat(p == 0 ? 2'd2 : 2'd3);
      for (int i = 0; i < 600; i++)
        step(($urandom % 4) == 0, ($urandom % 8) == 0, 2'($urandom),
             1'($urandom), 16'($urandom));
    end
    setLat(2'd3);

    done = 1'b1;
    finishRun();
  end
endmodule